// File: doc/BRIEF.md
# Two-to-One Transmit Byte Serializer

This block sits between a fabric-side transmit interface and a faster transceiver lane. It takes one wide parallel word and sends it out as two half-width words on consecutive cycles of a single fast clock, which runs at twice the input word rate. The lane can therefore run at a higher rate than the fabric interface would allow on its own. The lower half of each word always goes out first and the upper half second.

A configuration input picks the split. In wide mode a 20-bit word becomes two 10-bit halves. In narrow mode a 16-bit word becomes two 8-bit halves, and the top two output bits are held at zero. A word is taken on any fast-clock cycle where the input strobe is high. That cycle also realigns the internal phase, so the low half of the new word always follows it. An output valid flag marks every cycle that carries a half-word.

Top module: `byte_serializer_tx`

## Requirements
- R1: While reset (`rstN`, active low) is asserted, `outWord` is 0 and `outValid` is 0, regardless of the other inputs.
- R2: After reset, `outValid` stays 0 until the first cycle on which `inStrobe` is sampled high.
- R3: When `inStrobe` is sampled high with `wide20` = 1, the next cycle shows `outWord` = `inWord[9:0]` with `outValid` = 1.
- R4: If `inStrobe` is low on the cycle after a strobe, the following cycle shows the upper half of the captured word with `outValid` = 1. That is `inWord[19:10]` in wide mode and `{2'b00, inWord[15:8]}` in narrow mode.
- R5: With `wide20` = 0 at the strobe, the low half goes out as `{2'b00, inWord[7:0]}`. `outWord[9:8]` is 0 for both halves, and `inWord[19:16]` has no effect on the output.
- R6: A strobe on the cycle right after a strobe realigns the phase. The next cycle carries the low half of the new word, and the upper half still pending from the earlier word is never sent.
- R7: On a cycle with no half-word to send (no strobe on either of the two previous cycles), `outValid` is 0 and `outWord` keeps its last value.
- R8: The width mode is taken at the strobe. A change of `wide20` on the cycle between the two halves does not alter the upper half that follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast transmit clock, twice the input word rate |
| rstN | input | 1 | Asynchronous reset, active low |
| wide20 | input | 1 | 1 = 20-bit input split into 10-bit halves; 0 = 16-bit input split into 8-bit halves |
| inStrobe | input | 1 | Accept `inWord` on this cycle and realign the phase |
| inWord | input | 20 | Parallel word from the fabric |
| outWord | output | 10 | Half-word to the lane, low half first |
| outValid | output | 1 | High on each cycle that carries a half-word |

## Verification
A stuck or misaligned phase bit would first show up as an upper half appearing where a low half belongs. It could also show as a valid flag that stays high on an idle cycle. Either error is visible at the ports within two cycles of the strobe that exposes it. A stale holding register or a wrong mode capture would put wrong bits into the second half-word, and would corrupt the top two bits in narrow mode. A reference model of the output order is therefore compared with `outWord` and `outValid` on every cycle. The stimulus covers back-to-back strobes, gaps, mode flips between halves and a reset in the middle of a word.

// File: rtl/ser_tx_pkg.sv
package ser_tx_pkg;

  typedef struct packed {
    logic loadWord;
    logic sendUpper;
  } serStrobeT;

endpackage

// File: rtl/ser_tx_ctrl.sv
module ser_tx_ctrl
  import ser_tx_pkg::*;
#(
  parameter int SPLIT = 2,
  localparam int PH_W = (SPLIT > 2) ? $clog2(SPLIT) : 1
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      inStrobe,
  output serStrobeT strb,
  output logic      validQ
);

  logic [PH_W-1:0] halvesLeft;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      halvesLeft <= '0;
      validQ     <= 1'b0;
    end else begin
      if (inStrobe) begin
        halvesLeft <= PH_W'(SPLIT - 1);
      end else if (halvesLeft != '0) begin
        halvesLeft <= halvesLeft - 1'b1;
      end
      validQ <= inStrobe | (halvesLeft != '0);
    end
  end

  always_comb begin
    strb.loadWord  = inStrobe;
    strb.sendUpper = ~inStrobe & (halvesLeft != '0);
  end

endmodule

// File: rtl/ser_tx_datapath.sv
module ser_tx_datapath
  import ser_tx_pkg::*;
#(
  parameter int HALF_W   = 10,
  parameter int NARROW_W = 8,
  localparam int IN_W    = 2 * HALF_W,
  localparam int PAD_W   = HALF_W - NARROW_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wide20,
  input  logic [IN_W-1:0]   inWord,
  input  serStrobeT         strb,
  output logic [HALF_W-1:0] outWord
);

  logic [HALF_W-1:0] lowHalf;
  logic [HALF_W-1:0] highHalf;
  logic [HALF_W-1:0] upperHold;

  generate
    if (PAD_W > 0) begin : g_padded
      always_comb begin
        if (wide20) begin
          lowHalf  = inWord[HALF_W-1:0];
          highHalf = inWord[IN_W-1:HALF_W];
        end else begin
          lowHalf  = {{PAD_W{1'b0}}, inWord[NARROW_W-1:0]};
          highHalf = {{PAD_W{1'b0}}, inWord[2*NARROW_W-1:NARROW_W]};
        end
      end
    end else begin : g_flat
      always_comb begin
        lowHalf  = inWord[HALF_W-1:0];
        highHalf = inWord[IN_W-1:HALF_W];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      upperHold <= '0;
      outWord   <= '0;
    end else begin
      if (strb.loadWord) begin
        upperHold <= highHalf;
        outWord   <= lowHalf;
      end else if (strb.sendUpper) begin
        outWord   <= upperHold;
      end
    end
  end

endmodule

// File: rtl/byte_serializer_tx.sv
module byte_serializer_tx
  import ser_tx_pkg::*;
#(
  parameter int HALF_W   = 10,
  parameter int NARROW_W = 8,
  localparam int IN_W    = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wide20,
  input  logic              inStrobe,
  input  logic [IN_W-1:0]   inWord,
  output logic [HALF_W-1:0] outWord,
  output logic              outValid
);

  serStrobeT strb;

  ser_tx_ctrl #(
    .SPLIT(2)
  ) i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .inStrobe(inStrobe),
    .strb    (strb),
    .validQ  (outValid)
  );

  ser_tx_datapath #(
    .HALF_W  (HALF_W),
    .NARROW_W(NARROW_W)
  ) i_dp (
    .clk    (clk),
    .rstN   (rstN),
    .wide20 (wide20),
    .inWord (inWord),
    .strb   (strb),
    .outWord(outWord)
  );

endmodule

// File: rtl/ser_tx_checker.sv
module ser_tx_checker #(
  parameter int HALF_W   = 10,
  parameter int NARROW_W = 8,
  localparam int IN_W    = 2 * HALF_W
) (
  input logic              clk,
  input logic              rstN,
  input logic              wide20,
  input logic              inStrobe,
  input logic [IN_W-1:0]   inWord,
  input logic [HALF_W-1:0] outWord,
  input logic              outValid
);

  logic [1:0] upCnt;
  logic       seenStrobe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      upCnt      <= '0;
      seenStrobe <= 1'b0;
    end else begin
      if (upCnt != 2'd3) upCnt <= upCnt + 2'd1;
      if (inStrobe) seenStrobe <= 1'b1;
    end
  end

  p_reset_clear_r1: assert property (@(posedge clk)
    !rstN |=> (outWord == '0 && !outValid));

  p_quiet_before_first_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!seenStrobe && !inStrobe) |=> !outValid);

  p_low_first_r3: assert property (@(posedge clk) disable iff (!rstN)
    (inStrobe && wide20) |=> (outValid && outWord == $past(inWord[HALF_W-1:0])));

  p_upper_second_r4: assert property (@(posedge clk) disable iff (!rstN)
    (inStrobe && wide20) ##1 !inStrobe |=>
      (outValid && outWord == $past(inWord[IN_W-1:HALF_W], 2)));

  p_narrow_pad_r5: assert property (@(posedge clk) disable iff (!rstN)
    (inStrobe && !wide20) |=>
      (outWord[HALF_W-1:NARROW_W] == '0 &&
       outWord[NARROW_W-1:0] == $past(inWord[NARROW_W-1:0])));

  p_realign_r6: assert property (@(posedge clk) disable iff (!rstN)
    (upCnt != 2'd0 && inStrobe && $past(inStrobe) && wide20) |=>
      (outWord == $past(inWord[HALF_W-1:0])));

  p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (upCnt != 2'd0 && !inStrobe && !$past(inStrobe)) |=>
      (!outValid && $stable(outWord)));

endmodule

bind byte_serializer_tx ser_tx_checker #(
  .HALF_W  (HALF_W),
  .NARROW_W(NARROW_W)
) i_chk (
  .clk     (clk),
  .rstN    (rstN),
  .wide20  (wide20),
  .inStrobe(inStrobe),
  .inWord  (inWord),
  .outWord (outWord),
  .outValid(outValid)
);

// File: tb/test_byte_serializer_tx.sv
`timescale 1ns/1ps
module test_byte_serializer_tx;

  logic        clk = 1'b0;
  logic        rstN;
  logic        wide20;
  logic        inStrobe;
  logic [19:0] inWord;
  logic [9:0]  outWord;
  logic        outValid;

  int testsRun  = 0;
  int testsFail = 0;
  bit finished  = 1'b0;

  logic [9:0] pend[$];
  logic [9:0] mOut   = '0;
  logic       mValid = 1'b0;

  always #2 clk = ~clk;

  byte_serializer_tx i_byte_serializer_tx (
    .clk     (clk),
    .rstN    (rstN),
    .wide20  (wide20),
    .inStrobe(inStrobe),
    .inWord  (inWord),
    .outWord (outWord),
    .outValid(outValid)
  );

  task automatic model_edge();
    logic [9:0] lo, hi;
    if (!rstN) begin
      pend.delete();
      mOut   = '0;
      mValid = 1'b0;
    end else if (inStrobe) begin
      if (wide20) begin
        lo = inWord[9:0];
        hi = inWord[19:10];
      end else begin
        lo = {2'b00, inWord[7:0]};
        hi = {2'b00, inWord[15:8]};
      end
      pend.delete();
      pend.push_back(hi);
      mOut   = lo;
      mValid = 1'b1;
    end else if (pend.size() > 0) begin
      mOut   = pend.pop_front();
      mValid = 1'b1;
    end else begin
      mValid = 1'b0;
    end
  endtask

  task automatic step(input logic rst, input logic strobe, input logic mode,
                      input logic [19:0] word, input string tag);
    rstN     = rst;
    inStrobe = strobe;
    wide20   = mode;
    inWord   = word;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    testsRun++;
    if (outWord !== mOut || outValid !== mValid) begin
      testsFail++;
      $display("FAIL %s: outWord=%h outValid=%b expected outWord=%h outValid=%b",
               tag, outWord, outValid, mOut, mValid);
    end
  endtask

  initial begin
    rstN = 1'b0; inStrobe = 1'b0; wide20 = 1'b1; inWord = '0;
    @(negedge clk);
    // R1: reset dominates a strobe
    step(1'b0, 1'b1, 1'b1, 20'hABCDE, "R1");
    step(1'b0, 1'b1, 1'b0, 20'h12345, "R1");
    // R2: idle after reset
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 1'b1, 20'hFFFFF, "R2");
    // R3/R4: wide words every other cycle
    step(1'b1, 1'b1, 1'b1, 20'h3FF00, "R3");
    step(1'b1, 1'b0, 1'b1, 20'h00000, "R4");
    step(1'b1, 1'b1, 1'b1, 20'h5A5A5, "R3");
    step(1'b1, 1'b0, 1'b1, 20'hFFFFF, "R4");
    for (int i = 0; i < 6; i++) begin
      step(1'b1, 1'b1, 1'b1, 20'(32'h1F3 * (i + 7) ^ (i << 15)), "R3");
      step(1'b1, 1'b0, 1'b1, 20'hAAAAA, "R4");
    end
    // R7: gap holds last value, valid low
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 1'b1, 20'(i * 20'h1111), "R7");
    // R5: narrow mode, junk in bits 19:16
    step(1'b1, 1'b1, 1'b0, 20'hF81C3, "R5");
    step(1'b1, 1'b0, 1'b0, 20'hFFFFF, "R5");
    step(1'b1, 1'b1, 1'b0, 20'h9FFFF, "R5");
    step(1'b1, 1'b0, 1'b0, 20'h00000, "R5");
    step(1'b1, 1'b0, 1'b0, 20'h00000, "R7");
    // R6: back-to-back strobes realign
    step(1'b1, 1'b1, 1'b1, 20'h11111, "R6");
    step(1'b1, 1'b1, 1'b1, 20'h22222, "R6");
    step(1'b1, 1'b1, 1'b0, 20'h3C3C3, "R6");
    step(1'b1, 1'b0, 1'b1, 20'h00000, "R6");
    step(1'b1, 1'b0, 1'b1, 20'h00000, "R7");
    // R8: mode flips between halves
    step(1'b1, 1'b1, 1'b1, 20'hFFC00, "R8");
    step(1'b1, 1'b0, 1'b0, 20'h00000, "R8");
    step(1'b1, 1'b1, 1'b0, 20'hFFFFF, "R8");
    step(1'b1, 1'b0, 1'b1, 20'h00000, "R8");
    // R1: reset in the middle of a word, then R2 quiet again
    step(1'b1, 1'b1, 1'b1, 20'hBEEF1, "R3");
    step(1'b0, 1'b0, 1'b1, 20'h00000, "R1");
    step(1'b1, 1'b0, 1'b1, 20'h00000, "R2");
    step(1'b1, 1'b0, 1'b1, 20'h00000, "R2");
    step(1'b1, 1'b1, 1'b1, 20'h0F0F0, "R3");
    step(1'b1, 1'b0, 1'b1, 20'h00000, "R4");
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFail);
    $finish;
  end

  initial begin
    #20000;
    if (!finished) begin
      testsFail++;
      $display("FAIL watchdog: run hung, actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFail);
      $finish;
    end
  end

endmodule